// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Mode-Select Latch

This block is a serial test access port for one chip. The port has a clock, a mode-select line, a serial data input, a serial data output and an active-low asynchronous reset. A 16-state controller steps on the rising test-clock edge. It routes a 10-bit instruction register, or one of three data registers, between the serial input and the serial output. The three data registers are a one-bit bypass stage, a 32-bit identification register and a boundary register. The boundary register sits between the core and the pads. For each pad it has an input capture cell, an output data cell and an enable control cell. Each cell pairs a shift stage with an update latch.

A latch samples two emulation-select inputs on the rising edge of the test reset. Both inputs low selects normal boundary-scan operation. Any other value locks the port into a factory-test mode. In that mode every instruction behaves as bypass and the pads always follow the core. The port is purely serial, so it has no valid/ready handshake. Every control and pad pin is a plain level signal.

Top module: `scanport_top`

## Requirements
- R1: While `trst_n` is low the controller is held in Test-Logic-Reset. The current instruction is IDCODE, `tdo_en` is 0, and `pad_out`/`pad_oe` equal `core_out`/`core_oe`.
- R2: Under IDCODE, Capture-DR loads 32'h1805002F. The register then shifts out least significant bit first.
- R3: The instruction register is 10 bits. Capture-IR loads 10'b0000000001, and the register shifts least significant bit first. Opcodes: EXTEST 10'h000, SAMPLE 10'h004, IDCODE 10'h00C, HIGHZ 10'h018, BYPASS 10'h3FF. A new opcode takes effect at Update-IR.
- R4: Under BYPASS or HIGHZ a single stage sits between `tdi` and `tdo`. It captures 0, so the output is the input delayed by one shift.
- R5: The boundary register holds 3*NPIN cells, with cell 0 nearest `tdo`. For pad k, cell 3k captures `pin_in[k]`, cell 3k+1 captures `core_out[k]` and cell 3k+2 captures the inverse of `core_oe[k]`. Under SAMPLE the pads follow the core, and Update-DR loads the update latches.
- R6: Under EXTEST, `pad_out[k]` takes the update latch of cell 3k+1. `pad_oe[k]` is the inverse of the update latch of cell 3k+2, so a 1 in the control cell disables the pad. The update latches change only at Update-DR.
- R7: Under HIGHZ every `pad_oe` bit is 0.
- R8: An opcode outside the five listed behaves exactly as BYPASS.
- R9: Five consecutive rising `tck` edges with `tms` high reach Test-Logic-Reset from any state. The current instruction then becomes IDCODE.
- R10: Boundary-scan mode is selected only if `emu_sel` is 2'b00 at the rising edge of `trst_n`. Any other value selects factory-test mode. In that mode every opcode acts as BYPASS and the pads follow the core.
- R11: `tdo` and `tdo_en` change on the falling `tck` edge. `tdo_en` is 1 only while the controller is in Shift-DR or Shift-IR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low; its rising edge samples `emu_sel` |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| emu_sel | input | 2 | Emulation-select inputs for the mode latch |
| pin_in | input | NPIN | Values seen at the pads |
| core_out | input | NPIN | Core-side output values |
| core_oe | input | NPIN | Core-side output enables, 1 = drive |
| pad_out | output | NPIN | Values toward the pads |
| pad_oe | output | NPIN | Pad output enables, 1 = drive |
| tdo | output | 1 | Serial data out |
| tdo_en | output | 1 | Serial output enable, 1 = driving |

## Verification
The bench shifts the identification register and the bypass stage through the port and compares their serial outputs. This separates the 32-bit constant from the one-stage delay of a known byte. The boundary register is shifted with pads, core values and enables set to unequal patterns. A wrong cell order or a wrong inverted control bit therefore shows up in the captured stream. A preload with SAMPLE, followed by EXTEST and then HIGHZ, shows the difference between driving from the latches, disabling every pad and passing the core through. The factory-mode runs load EXTEST and IDCODE with `emu_sel` at 01 and at 10. Since both still behave as bypass there, they confirm the mode latch overrides the decoder.

// File: rtl/scanport_pkg.sv
package scanport_pkg;
  localparam int IR_W = 10;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef enum logic [2:0] {I_EXTEST, I_SAMPLE, I_IDCODE, I_BYPASS, I_HIGHZ} instr_t;

  localparam logic [IR_W-1:0] OP_EXTEST = 10'h000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 10'h004;
  localparam logic [IR_W-1:0] OP_IDCODE = 10'h00C;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 10'h018;
  localparam logic [IR_W-1:0] OP_BYPASS = 10'h3FF;
  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};
endpackage

// File: rtl/scanport_fsm.sv
module scanport_fsm
  import scanport_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      default:   nxt = tms ? ST_SEL_DR : ST_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

  // checker: count consecutive tms-high edges, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           ones_q <= 3'd0;
    else if (!tms)         ones_q <= 3'd0;
    else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
  end

  assert_five_ones_reset_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_q == 3'd5) |-> (state == ST_TLR));
endmodule

// File: rtl/scanport_ir.sv
module scanport_ir
  import scanport_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_t state,
  input  logic       bs_mode,
  output logic       ir_tdo,
  output instr_t     sel
);
  logic [IR_W-1:0] ir_sr, ir_cur;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr  <= '0;
      ir_cur <= OP_IDCODE;
    end else begin
      unique case (state)
        ST_TLR:    ir_cur <= OP_IDCODE;
        ST_CAP_IR: ir_sr  <= IR_CAPTURE;
        ST_SHF_IR: ir_sr  <= {tdi, ir_sr[IR_W-1:1]};
        ST_UPD_IR: ir_cur <= ir_sr;
        default:   ;
      endcase
    end
  end

  assign ir_tdo = ir_sr[0];

  always_comb begin
    if (!bs_mode) sel = I_BYPASS;
    else begin
      unique case (ir_cur)
        OP_EXTEST: sel = I_EXTEST;
        OP_SAMPLE: sel = I_SAMPLE;
        OP_IDCODE: sel = I_IDCODE;
        OP_HIGHZ:  sel = I_HIGHZ;
        default:   sel = I_BYPASS;
      endcase
    end
  end

  assert_ir_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == IR_CAPTURE));
  assert_reset_loads_idcode_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |=> (ir_cur == OP_IDCODE));
endmodule

// File: rtl/scanport_bsr.sv
module scanport_bsr
  import scanport_pkg::*;
#(
  parameter int NPIN = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_t      state,
  input  logic            active,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic [NPIN-1:0] upd_out,
  output logic [NPIN-1:0] upd_dis,
  output logic            bsr_tdo
);
  localparam int LEN = 3 * NPIN;

  logic [LEN-1:0] sh_q, upd_q, cap_v;

  for (genvar k = 0; k < NPIN; k++) begin : g_pad
    assign cap_v[3*k]   = pin_in[k];
    assign cap_v[3*k+1] = core_out[k];
    assign cap_v[3*k+2] = ~core_oe[k];
    assign upd_out[k]   = upd_q[3*k+1];
    assign upd_dis[k]   = upd_q[3*k+2];
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sh_q  <= '0;
      upd_q <= '0;
    end else if (active) begin
      unique case (state)
        ST_CAP_DR: sh_q  <= cap_v;
        ST_SHF_DR: sh_q  <= {tdi, sh_q[LEN-1:1]};
        ST_UPD_DR: upd_q <= sh_q;
        default:   ;
      endcase
    end
  end

  assign bsr_tdo = sh_q[0];

  assert_update_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_DR) |=> $stable(upd_q));
endmodule

// File: rtl/scanport_top.sv
module scanport_top
  import scanport_pkg::*;
#(
  parameter int          NPIN   = 4,
  parameter int          ID_W   = 32,
  parameter logic [31:0] ID_VAL = 32'h1805002F
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  input  logic [1:0]      emu_sel,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] core_out,
  input  logic [NPIN-1:0] core_oe,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            tdo,
  output logic            tdo_en
);
  tap_state_t      state;
  instr_t          sel;
  logic            ir_tdo, bsr_tdo, bsr_on, byp_q, tdo_d, bs_mode_q;
  logic [ID_W-1:0] id_q;
  logic [NPIN-1:0] upd_out, upd_dis;

  // mode latch: samples the emulation selects on the release of test reset
  always_ff @(posedge trst_n) bs_mode_q <= (emu_sel == 2'b00);

  scanport_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  scanport_ir u_ir (.tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
                    .bs_mode(bs_mode_q), .ir_tdo(ir_tdo), .sel(sel));

  assign bsr_on = (sel == I_EXTEST) || (sel == I_SAMPLE);

  scanport_bsr #(.NPIN(NPIN)) u_bsr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .active(bsr_on),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .upd_out(upd_out), .upd_dis(upd_dis), .bsr_tdo(bsr_tdo));

  // identification and bypass data registers
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_q  <= '0;
      byp_q <= 1'b0;
    end else if (sel == I_IDCODE) begin
      if (state == ST_CAP_DR)      id_q <= ID_VAL[ID_W-1:0];
      else if (state == ST_SHF_DR) id_q <= {tdi, id_q[ID_W-1:1]};
    end else if (!bsr_on) begin
      if (state == ST_CAP_DR)      byp_q <= 1'b0;
      else if (state == ST_SHF_DR) byp_q <= tdi;
    end
  end

  always_comb begin
    if (state == ST_SHF_IR) tdo_d = ir_tdo;
    else begin
      unique case (sel)
        I_EXTEST, I_SAMPLE: tdo_d = bsr_tdo;
        I_IDCODE:           tdo_d = id_q[0];
        default:            tdo_d = byp_q;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= (state == ST_SHF_DR) || (state == ST_SHF_IR);
    end
  end

  always_comb begin
    unique case (sel)
      I_EXTEST: begin pad_out = upd_out;  pad_oe = ~upd_dis; end
      I_HIGHZ:  begin pad_out = core_out; pad_oe = '0;       end
      default:  begin pad_out = core_out; pad_oe = core_oe;  end
    endcase
  end

  assert_tdo_quiet_R11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == ST_SHF_DR || state == ST_SHF_IR));
  assert_factory_passthru_R10: assert property (@(posedge tck) disable iff (!trst_n)
    !bs_mode_q |-> (pad_out == core_out && pad_oe == core_oe));
  assert_highz_off_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (sel == I_HIGHZ) |-> (pad_oe == '0));
endmodule

// File: tb/scanport_top_test.sv
module scanport_top_test;
  localparam int TCK_PERIOD = 20;
  localparam int NPIN = 4;
  localparam int LEN  = 3 * NPIN;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [1:0] emu_sel = 2'b00;
  logic [NPIN-1:0] pin_in = '0, core_out = '0, core_oe = '0;
  logic [NPIN-1:0] pad_out, pad_oe;
  logic tdo, tdo_en;

  int checks = 0, errors = 0;
  bit done = 0;
  bit exp_q[$];
  string req_q[$];

  scanport_top #(.NPIN(NPIN)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .emu_sel(emu_sel),
    .pin_in(pin_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .tdo(tdo), .tdo_en(tdo_en));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // monitor: every shifted-out bit is compared against the scoreboard queue
  always @(posedge tck) begin
    if (tdo_en) begin
      if (exp_q.size() == 0) check(1'b0, "R11", {63'd0, tdo}, 64'd0);
      else begin
        bit e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(tdo == e, r, {63'd0, tdo}, {63'd0, e});
      end
    end
  end

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    #(TCK_PERIOD/2); tck = 1'b1;
    #(TCK_PERIOD/2); tck = 1'b0;
    #1;
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic shift_ir(input logic [9:0] op);
    for (int i = 0; i < 10; i++) begin
      exp_q.push_back(i == 0);
      req_q.push_back("R3");
    end
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 10; i++) step(i == 9, op[i]);
    step(1, 0); step(0, 0);
    check(tdo_en == 1'b0, "R11", {63'd0, tdo_en}, 64'd0);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, input logic [31:0] exp, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(exp[i]);
      req_q.push_back(req);
    end
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 0); step(0, 0);
  endtask

  task automatic do_reset(input logic [1:0] emu);
    tck = 1'b0; tms = 1'b1;
    trst_n = 1'b0; emu_sel = emu;
    #(TCK_PERIOD);
    trst_n = 1'b1;
    #(TCK_PERIOD);
  endtask

  task automatic pads_follow(input string req);
    check(pad_out == core_out, req, {60'd0, pad_out}, {60'd0, core_out});
    check(pad_oe == core_oe, req, {60'd0, pad_oe}, {60'd0, core_oe});
  endtask

  function automatic logic [LEN-1:0] cap_model(input logic [NPIN-1:0] p, input logic [NPIN-1:0] co, input logic [NPIN-1:0] oe);
    logic [LEN-1:0] v;
    for (int k = 0; k < NPIN; k++) begin
      v[3*k] = p[k]; v[3*k+1] = co[k]; v[3*k+2] = ~oe[k];
    end
    return v;
  endfunction

  function automatic logic [LEN-1:0] preload(input logic [NPIN-1:0] o, input logic [NPIN-1:0] dis);
    logic [LEN-1:0] v;
    for (int k = 0; k < NPIN; k++) begin
      v[3*k] = 1'b0; v[3*k+1] = o[k]; v[3*k+2] = dis[k];
    end
    return v;
  endfunction

  function automatic logic [31:0] byp_exp(input logic [7:0] d);
    return {24'd0, d[6:0], 1'b0};
  endfunction

  initial begin
    #(TCK_PERIOD * 200000);
    check(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [LEN-1:0] pat;
    pin_in = 4'b1010; core_out = 4'b0110; core_oe = 4'b1100;
    // R1: reset state
    trst_n = 1'b0; #(TCK_PERIOD);
    check(tdo_en == 1'b0, "R1", {63'd0, tdo_en}, 64'd0);
    pads_follow("R1");
    trst_n = 1'b1; #(TCK_PERIOD);
    step(0, 0);
    // R2: identification register after reset
    shift_dr(32, 32'h0, 32'h1805002F, "R2");
    // R4: bypass delays by one stage
    shift_ir(10'h3FF);
    shift_dr(8, 32'hB5, byp_exp(8'hB5), "R4");
    // R8: undefined opcode acts as bypass
    shift_ir(10'h155);
    shift_dr(8, 32'h3C, byp_exp(8'h3C), "R8");
    pads_follow("R8");
    // R5: SAMPLE capture order and preload
    pat = preload(4'b1101, 4'b0100);
    shift_ir(10'h004);
    shift_dr(LEN, {20'd0, pat}, {20'd0, cap_model(pin_in, core_out, core_oe)}, "R5");
    pads_follow("R5");
    // R6: EXTEST drives pads from update latches
    shift_ir(10'h000);
    check(pad_out == 4'b1101, "R6", {60'd0, pad_out}, 64'hD);
    check(pad_oe == 4'b1011, "R6", {60'd0, pad_oe}, 64'hB);
    pin_in = 4'b0101;
    shift_dr(LEN, {20'd0, pat}, {20'd0, cap_model(4'b0101, core_out, core_oe)}, "R6");
    check(pad_oe == 4'b1011, "R6", {60'd0, pad_oe}, 64'hB);
    // R7: HIGHZ disables every pad, bypass in path (R4)
    shift_ir(10'h018);
    check(pad_oe == 4'b0000, "R7", {60'd0, pad_oe}, 64'h0);
    shift_dr(8, 32'h96, byp_exp(8'h96), "R4");
    // R9: five tms-high clocks return to IDCODE
    shift_ir(10'h000);
    for (int i = 0; i < 5; i++) step(1, 0);
    pads_follow("R9");
    step(0, 0);
    shift_dr(32, 32'h0, 32'h1805002F, "R9");
    // R10: factory-test mode, emu_sel 01
    do_reset(2'b01);
    step(0, 0);
    shift_ir(10'h000);
    pads_follow("R10");
    shift_dr(8, 32'h5A, byp_exp(8'h5A), "R10");
    shift_ir(10'h00C);
    shift_dr(8, 32'hC3, byp_exp(8'hC3), "R10");
    // R10: emu_sel 10 also locks, then 00 restores boundary scan
    do_reset(2'b10);
    step(0, 0);
    shift_dr(8, 32'h81, byp_exp(8'h81), "R10");
    do_reset(2'b00);
    step(0, 0);
    shift_dr(32, 32'h0, 32'h1805002F, "R10");
    check(exp_q.size() == 0, "R11", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule